// File: doc/BRIEF.md
# Configurable Serial Transmitter

The block sends one character at a time on a single serial output line. A 31-bit setup word gives every line parameter at once: how many clocks each bit lasts, how many data bits a character has (five to eight), whether one or two stop bits follow, and the parity mode (none, even, odd, or a parity bit fixed at 1 or at 0). The line is held high whenever no frame is in progress.

A character is offered by raising `wr_i` with the byte on `data_i`. It is taken in any cycle in which `busy_o` is low. The setup word and the data are captured together at that moment. A setup change made while a frame is being sent only affects the next character. A setup value of 868 gives eight data bits, one stop bit, no parity and an 868-clock bit period, which is 115200 baud from a 100 MHz clock.

Top module: `serial_tx`

## Requirements
- R1: After reset, `tx_o` is high and `busy_o` is low.
- R2: `setup_i[23:0]` is the bit period in clocks, and every bit on the line lasts exactly that many clocks. A value of 0 is treated as 1.
- R3: A frame is one low start bit, then the data bits LSB first, then the parity bit if parity is on, then the stop bits, which are high. The line is high whenever `busy_o` is low.
- R4: `setup_i[29:28]` sets the data width: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Bits of `data_i` above the selected width have no effect on the line.
- R5: `setup_i[27]` = 1 sends two stop bits, and `setup_i[27]` = 0 sends one.
- R6: `setup_i[26]` = 1 adds a parity bit. The mode is set by {`setup_i[25]`, `setup_i[24]`}: 00 is even, 01 is odd, 10 is a bit that is always 0, and 11 is a bit that is always 1. `setup_i[30]` has no effect.
- R7: A write made while `busy_o` is low is accepted at that clock edge. `busy_o` is high from the next cycle for exactly (frame bits × bit period) cycles, and the start bit appears in that same first cycle.
- R8: A write made while `busy_o` is high is ignored. It neither changes the frame in progress nor starts a later one.
- R9: `setup_i` and `data_i` are sampled only when a write is accepted. Changing them during a frame has no effect on that frame.
- R10: If `wr_i` is held high, the next character is accepted in the first cycle in which `busy_o` is low. Exactly one idle-high clock then separates the last stop bit from the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 31 | Line setup word: bit period, data width, stop bits, parity |
| wr_i | input | 1 | Request to send `data_i` |
| data_i | input | 8 | Character to send, LSB first |
| busy_o | output | 1 | High while a frame is on the line |
| tx_o | output | 1 | Serial output line, idle high |

## Verification
Two events can fall in the same cycle. A new write can meet the final bit-period tick of the last stop bit, and a setup or data change can meet a frame that is already running. The first case is provoked by holding `wr_i` high through a whole frame. The bench then expects `busy_o` low with the line high for exactly one cycle, followed at once by a start bit. The second case is provoked by changing `setup_i` and `data_i` and pulsing `wr_i` in the middle of a frame. The bench then requires every bit to match the frame computed from the values present when the write was accepted, and it requires that no second frame follows.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'b00,
    PAR_ODD   = 2'b01,
    PAR_SPACE = 2'b10,
    PAR_MARK  = 2'b11
  } par_mode_e;

  // Format fields above the divider, MSB first: width code, two-stop, parity enable, parity mode
  typedef struct packed {
    logic [1:0] width_code;
    logic       two_stop;
    logic       par_en;
    par_mode_e  par_mode;
  } fmt_t;

  localparam int unsigned FMT_W = $bits(fmt_t);

endpackage

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 4,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  fmt_t               fmt_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);

  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] masked;
  logic              par_bit;

  assign nbits = LEN_W'(DATA_W) - LEN_W'(fmt_i.width_code);

  for (genvar j = 0; j < DATA_W; j++) begin : g_mask
    assign masked[j] = data_i[j] & (LEN_W'(j) < nbits);
  end

  always_comb begin
    unique case (fmt_i.par_mode)
      PAR_EVEN:  par_bit = ^masked;
      PAR_ODD:   par_bit = ~(^masked);
      PAR_SPACE: par_bit = 1'b0;
      default:   par_bit = 1'b1;
    endcase
  end

  assign frame_o[0] = 1'b0;

  for (genvar j = 1; j < FRAME_W; j++) begin : g_pos
    logic is_par;
    assign is_par = fmt_i.par_en && (LEN_W'(j) == nbits + LEN_W'(1));
    if (j <= DATA_W) begin : g_dat
      assign frame_o[j] = (LEN_W'(j) <= nbits) ? data_i[j-1] :
                          is_par               ? par_bit     : 1'b1;
    end else begin : g_tail
      assign frame_o[j] = is_par ? par_bit : 1'b1;
    end
  end

  assign len_o = LEN_W'(2) + nbits + LEN_W'(fmt_i.par_en) + LEN_W'(fmt_i.two_stop);

endmodule

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] reload_q, cnt_q, per_eff;

  assign per_eff = (div_i == '0) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= per_eff - DIV_W'(1);
      cnt_q    <= per_eff - DIV_W'(1);
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_q); // R2

  AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == reload_q); // R2

endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned LEN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               tx_o
);

  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (start_i) begin
      tx_q   <= frame_i[0];
      sh_q   <= {1'b1, frame_i[FRAME_W-1:1]};
      left_q <= len_i - LEN_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (left_q != '0) begin
        tx_q   <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - LEN_W'(1);
      end else begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = tx_q;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_q); // R3

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && !tx_q); // R3

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> busy_q && $stable(tx_q)); // R2

  AST_LAST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && tick_i && (left_q == '0) |-> tx_q); // R5

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i); // R8

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SETUP_W = DIV_W + FMT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               busy_o,
  output logic               tx_o
);

  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  fmt_t               fmt;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               accept, tick;
  logic               spare_unused;

  assign fmt          = fmt_t'(setup_i[DIV_W +: FMT_W]);
  assign spare_unused = setup_i[SETUP_W-1];
  assign accept       = wr_i && !busy_o;

  serial_tx_framer #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_framer (
    .fmt_i  (fmt),
    .data_i (data_i),
    .frame_o(frame),
    .len_o  (len)
  );

  serial_tx_baud #(
    .DIV_W(DIV_W)
  ) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .div_i (setup_i[DIV_W-1:0]),
    .run_i (busy_o),
    .tick_o(tick)
  );

  serial_tx_shift #(
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .frame_i(frame),
    .len_i  (len),
    .tick_i (tick),
    .busy_o (busy_o),
    .tx_o   (tx_o)
  );

  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_i && !tick |=> busy_o && $stable(tx_o)); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !busy_o |=> busy_o); // R7

endmodule

// File: tb/serial_tx_test.sv
module serial_tx_test;

  logic        clk_i   = 1'b0;
  logic        rst_ni  = 1'b0;
  logic [30:0] setup_i = 31'd868;
  logic        wr_i    = 1'b0;
  logic [7:0]  data_i  = 8'h00;
  logic        busy_o, tx_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  serial_tx uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .setup_i(setup_i),
    .wr_i   (wr_i),
    .data_i (data_i),
    .busy_o (busy_o),
    .tx_o   (tx_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame from the requirement text (R2..R6)
  function automatic void exp_frame(input logic [30:0] s, input logic [7:0] d,
                                    output logic [11:0] f, output int len,
                                    output int div);
    int nb;
    bit par;
    nb  = 8 - int'(s[29:28]);
    f   = '1;
    f[0] = 1'b0;
    par = 1'b0;
    for (int i = 0; i < nb; i++) begin
      f[1+i] = d[i];
      par ^= d[i];
    end
    len = 1 + nb;
    if (s[26]) begin
      f[len] = s[25] ? s[24] : (par ^ s[24]);
      len++;
    end
    len += 1 + int'(s[27]);
    div = (s[23:0] == 0) ? 1 : int'(s[23:0]);
  endfunction

  task automatic run_frame(input string req, input logic [30:0] s,
                           input logic [7:0] d, input logic [30:0] s_mid,
                           input bit poke, input bit hold);
    logic [11:0] f;
    int len, div, total, bad_bit, bad_busy;
    exp_frame(s, d, f, len, div);
    total = len * div;
    @(negedge clk_i);
    setup_i = s;
    data_i  = d;
    wr_i    = 1'b1;
    @(posedge clk_i);
    bad_bit  = 0;
    bad_busy = 0;
    for (int c = 0; c < total; c++) begin
      @(negedge clk_i);
      if (!hold) wr_i = poke && (c == 2);
      if (c == 1) setup_i = s_mid;
      if (poke) data_i = ~d;
      if (tx_o !== f[c/div]) bad_bit++;
      if (busy_o !== 1'b1) bad_busy++;
      if ((c % div) == div - 1) begin
        chk(bad_bit == 0, req, $sformatf("bit %0d level", c/div), int'(tx_o), int'(f[c/div]));
        bad_bit = 0;
      end
    end
    chk(bad_busy == 0, "R7", "busy during frame (cycles low)", bad_busy, 0);
    @(negedge clk_i);
    chk(busy_o === 1'b0, "R7", "busy after frame", int'(busy_o), 0);
    chk(tx_o === 1'b1, "R3", "line idle after frame", int'(tx_o), 1);
    if (hold) begin
      @(negedge clk_i);
      chk(tx_o === 1'b0, "R10", "start bit after one idle clock", int'(tx_o), 0);
      chk(busy_o === 1'b1, "R10", "busy on back-to-back", int'(busy_o), 1);
      wr_i = 1'b0;
      while (busy_o) @(negedge clk_i);
    end else begin
      @(negedge clk_i);
      chk(busy_o === 1'b0, "R8", "no frame from write while busy", int'(busy_o), 0);
      chk(tx_o === 1'b1, "R8", "line stays idle", int'(tx_o), 1);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(tx_o === 1'b1, "R1", "tx in reset", int'(tx_o), 1);
    chk(busy_o === 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_o === 1'b1, "R1", "tx after reset", int'(tx_o), 1);
    chk(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
  endtask

  task automatic t_basic();
    logic [30:0] s = 31'd4;
    run_frame("R3", s, 8'hA5, s, 1'b0, 1'b0);
    run_frame("R3", s, 8'h5A, s, 1'b0, 1'b0);
  endtask

  task automatic t_default_868();
    run_frame("R2", 31'd868, 8'h3C, 31'd868, 1'b0, 1'b0);
  endtask

  task automatic t_widths_parity();
    logic [30:0] s;
    s = (31'd1 << 28) | (31'd1 << 27) | (31'd1 << 26) | 31'd3;
    run_frame("R4 R5 R6 even", s, 8'hFF, s, 1'b0, 1'b0);
    s = (31'd3 << 28) | (31'd1 << 26) | (31'd1 << 24) | 31'd5;
    run_frame("R4 R6 odd", s, 8'hE6, s, 1'b0, 1'b0);
    s = (31'd2 << 28) | (31'd7 << 24) | 31'd2;
    run_frame("R4 R6 mark", s, 8'h00, s, 1'b0, 1'b0);
    s = (31'd6 << 24) | (31'd1 << 27) | 31'd3;
    run_frame("R5 R6 space", s, 8'hFF, s, 1'b0, 1'b0);
  endtask

  task automatic t_div_zero_spare();
    logic [30:0] s = (31'd1 << 30) | (31'd1 << 26);
    run_frame("R2 R6 div0", s, 8'h81, s, 1'b0, 1'b0);
  endtask

  task automatic t_mid_change();
    logic [30:0] s  = (31'd1 << 26) | 31'd4;
    logic [30:0] s2 = (31'd3 << 28) | (31'd1 << 24) | 31'd2;
    run_frame("R8 R9 frozen", s, 8'h6D, s2, 1'b1, 1'b0);
    run_frame("R9 next uses new", s2, 8'h6D, s2, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    logic [30:0] s = 31'd3;
    run_frame("R10 first", s, 8'hC3, s, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_default_868();
    t_widths_parity();
    t_div_zero_spare();
    t_mid_change();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule